// File: doc/BRIEF.md
# Weighted Pipelined-ADC Code Reconstructor

This block turns the raw two-bit decisions of a chain of 1.5-bit pipeline stages into a single signed fixed-point value. Every stage has its own programmable weight. These weights replace the ideal factor of one half, so a stage whose interstage gain is not exactly 2 can still be reconstructed accurately. The per-stage codes sit in a small register file. Codes and weights are written through simple write ports.

A start pulse selects the first stage to include. The block then works from the last stage, a 2-bit flash, back toward the selected stage, one stage per clock. For each stage it forms the stage's signed digit plus the weight times the value already accumulated from the stages behind it. Starting at a stage other than the first lets the block act as a calibrated back end while a front stage is being measured. The result is held until the next reconstruction finishes, and a one-cycle done strobe marks when it is ready.

The default chain has 14 stages: 13 stages of 1.5 bits and a flash at stage 14. Values use a signed 32-bit word with 24 fractional bits (Q7.24), so 1.0 is 0x01000000.

Top module: `pipe_recon`

## Requirements
- R1: After reset, result, done, busy and code_err are 0, every stage code is 01 and every stage weight is 0.5 (0x00800000).
- R2: A stage code maps to a signed digit as follows: 00 gives −1.0, 01 gives 0 and 10 gives +1.0.
- R3: The flash code c at stage 14 (0 to 3) contributes the value c/2 − 0.75.
- R4: For each stage k from 13 down to the start stage, the accumulator becomes digit(k) + ((w(k) × acc) arithmetically shifted right by 24). The weight w(k) is the value last written for stage k.
- R5: A start with start_sel = i uses stages i through 14. With i = 14 the result is the flash value alone. A start_sel of 0 is treated as 1, and values above 14 are treated as 14.
- R6: busy is high from the edge that samples start until done. done is a single-cycle pulse that goes high at the (15 − i)-th rising edge after the edge that sampled start.
- R7: result changes only when done is high. Between completions it holds, whatever is written to codes or weights.
- R8: A stage code of 11 that is used in a reconstruction counts as digit 0 and sets code_err. code_err stays set until the next start clears it.
- R9: Each accumulation step saturates to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow.
- R10: A start that arrives while busy is high abandons the running reconstruction and begins a new one with the new start_sel. No done is produced for the abandoned one.
- R11: Weights can be written for stages 1 to 13 and codes for stages 1 to 14. Writes to other indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_en | input | 1 | Stage code write enable |
| cw_sel | input | 4 | Stage index for the code write |
| cw_code | input | 2 | Two-bit stage code to store |
| ww_en | input | 1 | Weight write enable |
| ww_sel | input | 4 | Stage index for the weight write |
| ww_val | input | 32 | Q7.24 signed weight |
| start | input | 1 | Begin reconstruction |
| start_sel | input | 4 | First stage to include |
| busy | output | 1 | Reconstruction in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Q7.24 signed reconstructed value |
| code_err | output | 1 | Sticky illegal-code flag |

## Verification
The embedded properties assume that the code and weight tables are not rewritten while busy is high. If they were, the value being accumulated would mix old and new entries, although the pointer and strobe properties would still hold. The stimulus writes codes and weights only while the block is idle, then issues a single start pulse and waits for done. The one exception is a deliberate restart that tests R10. The sweeps cover every legal code of the last three 1.5-bit stages and every flash code, for each start stage from 11 to 14. They also cover full-chain runs with varied weights, an illegal code, saturation in both directions and clamping of start_sel.

// File: rtl/pipe_recon.sv
module pipe_recon #(
  parameter int NSTG = 14,
  parameter int WW   = 32,
  parameter int FB   = 24,
  localparam int IW  = $clog2(NSTG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_en,
  input  logic [IW-1:0] cw_sel,
  input  logic [1:0]    cw_code,
  input  logic          ww_en,
  input  logic [IW-1:0] ww_sel,
  input  logic [WW-1:0] ww_val,
  input  logic          start,
  input  logic [IW-1:0] start_sel,
  output logic          busy,
  output logic          done,
  output logic [WW-1:0] result,
  output logic          code_err
);
  localparam int WL = 2 * WW;
  localparam int NE = 1 << IW;
  localparam logic signed [WW-1:0] ONE  = WW'(1) << FB;
  localparam logic signed [WW-1:0] HALF = WW'(1) << (FB - 1);
  localparam logic signed [WL-1:0] HI = {{(WW+1){1'b0}}, {(WW-1){1'b1}}};
  localparam logic signed [WL-1:0] LO = {{(WW+1){1'b1}}, {(WW-1){1'b0}}};

  logic [1:0]              codes [NE];
  logic signed [WW-1:0]    wts   [NE];
  logic signed [WW-1:0]    acc, dig, fval, nacc;
  logic signed [WL-1:0]    prod, sh, sum;
  logic [IW-1:0]           ptr, idx, nxt, sel_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NE; j++) begin
        codes[j] <= 2'b01;
        wts[j]   <= HALF;
      end
    end else begin
      if (cw_en && cw_sel != '0 && int'(cw_sel) <= NSTG)
        codes[cw_sel] <= cw_code;
      if (ww_en && ww_sel != '0 && int'(ww_sel) < NSTG)
        wts[ww_sel] <= ww_val;
    end
  end

  assign sel_c = (start_sel == '0) ? IW'(1) :
                 (int'(start_sel) > NSTG) ? IW'(NSTG) : start_sel;
  assign nxt   = ptr - 1'b1;
  assign fval  = (WW'(codes[NSTG]) << (FB - 1)) - (WW'(3) << (FB - 2));

  always_comb begin
    case (codes[nxt])
      2'b00:   dig = -ONE;
      2'b10:   dig = ONE;
      default: dig = '0;
    endcase
  end

  assign prod = WL'(wts[nxt]) * WL'(acc);
  assign sh   = prod >>> FB;
  assign sum  = sh + WL'(dig);
  assign nacc = (sum > HI) ? HI[WW-1:0] : (sum < LO) ? LO[WW-1:0] : sum[WW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      code_err <= 1'b0;
      acc      <= '0;
      ptr      <= '0;
      idx      <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        ptr      <= IW'(NSTG);
        idx      <= sel_c;
        acc      <= fval;
        code_err <= 1'b0;
      end else if (busy) begin
        if (ptr == idx) begin
          result <= acc;
          done   <= 1'b1;
          busy   <= 1'b0;
        end else begin
          acc <= nacc;
          ptr <= nxt;
          if (codes[nxt] == 2'b11) code_err <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && !busy);
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done);
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_err && !start |=> code_err);
  p_err_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_err) |-> $past(busy));
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ptr >= idx && idx != '0 && int'(ptr) <= NSTG);
endmodule

// File: tb/pipe_recon_bench.sv
module pipe_recon_bench;
  logic        clk = 0, rst_n = 0;
  logic        cw_en = 0, ww_en = 0, start = 0;
  logic [3:0]  cw_sel = 0, ww_sel = 0, start_sel = 0;
  logic [1:0]  cw_code = 0;
  logic [31:0] ww_val = 0;
  logic        busy, done, code_err;
  logic [31:0] result;

  int checks = 0, fails = 0;
  int bc [15];
  longint bw [15];
  int lf = 32'h1234567;

  always #2 clk = ~clk;

  pipe_recon u_pipe_recon (.clk, .rst_n, .cw_en, .cw_sel, .cw_code, .ww_en, .ww_sel,
    .ww_val, .start, .start_sel, .busy, .done, .result, .code_err);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint satv(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint model(int i);
    longint a, d;
    a = longint'(bc[14]) * 8388608 - 3 * 4194304;
    for (int k = 13; k >= i; k--) begin
      d = (bc[k] == 0) ? -16777216 : (bc[k] == 2) ? 16777216 : 0;
      a = satv(((bw[k] * a) >>> 24) + d);
    end
    return a;
  endfunction

  task automatic wcode(int s, int c);
    @(negedge clk); cw_en = 1; cw_sel = 4'(s); cw_code = 2'(c);
    @(negedge clk); cw_en = 0;
    if (s >= 1 && s <= 14) bc[s] = c;
  endtask

  task automatic wwt(int s, longint w);
    @(negedge clk); ww_en = 1; ww_sel = 4'(s); ww_val = 32'(w);
    @(negedge clk); ww_en = 0;
    if (s >= 1 && s <= 13) bw[s] = w;
  endtask

  task automatic run(int sel, int i, string req);
    int e;
    @(negedge clk); start = 1; start_sel = 4'(sel);
    @(negedge clk); start = 0; e = 1;
    chk({req, "/R6 busy"}, longint'(busy), 1);
    while (!done && e < 40) begin @(negedge clk); e++; end
    chk({req, "/R6 latency"}, e, 16 - i);
    chk(req, longint'($signed(result)), model(i));
    @(negedge clk);
    chk({req, "/R6 pulse"}, longint'(done), 0);
  endtask

  function automatic int rnd();
    lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
    return lf & 32'h7fffffff;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint held;
    for (int k = 0; k < 15; k++) begin bc[k] = 1; bw[k] = 8388608; end
    repeat (3) @(negedge clk);
    chk("R1 result", result, 0); chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);     chk("R1 err", code_err, 0);
    rst_n = 1;
    run(1, 1, "R1 default weights all-zero codes");
    wcode(13, 2); wcode(14, 3);
    run(13, 13, "R1 default weight half");

    wwt(11, 7885292); wwt(12, 8388608); wwt(13, 8724152);
    for (int i = 11; i <= 14; i++)
      for (int c11 = 0; c11 < 3; c11++)
        for (int c12 = 0; c12 < 3; c12++)
          for (int c13 = 0; c13 < 3; c13++)
            for (int f = 0; f < 4; f++) begin
              wcode(11, c11); wcode(12, c12); wcode(13, c13); wcode(14, f);
              run(i, i, "R2/R3/R4/R5 sweep");
              chk("R8 no err on legal codes", code_err, 0);
            end

    for (int t = 0; t < 12; t++) begin
      for (int k = 1; k <= 13; k++) begin
        wcode(k, rnd() % 3);
        wwt(k, 8388608 + (rnd() % 800001) - 400000);
      end
      wcode(14, rnd() % 4);
      run(1, 1, "R4/R11 full chain");
    end

    run(0, 1, "R5 clamp zero");
    run(15, 14, "R5 clamp high");

    wcode(12, 3);
    run(11, 11, "R8 illegal as zero");
    chk("R8 err set", code_err, 1);
    repeat (3) @(negedge clk);
    chk("R8 err sticky", code_err, 1);
    wcode(12, 1);
    run(11, 11, "R8 restart legal");
    chk("R8 err cleared", code_err, 0);

    held = $signed(result);
    wcode(11, 0); wwt(11, 3 * 16777216); wcode(14, 0);
    repeat (4) @(negedge clk);
    chk("R7 hold", longint'($signed(result)), held);
    wcode(11, 1); wcode(14, 1); wwt(11, 8388608);

    wwt(14, 99); wcode(0, 2); wwt(0, 99);
    chk("R11 ignored writes", longint'($signed(result)), held);
    run(12, 12, "R11 out-of-range writes no effect");

    for (int k = 1; k <= 13; k++) begin wcode(k, 2); wwt(k, 100 * 16777216); end
    wcode(14, 3);
    run(8, 8, "R9 positive saturation");
    chk("R9 top", result, 32'h7fffffff);
    for (int k = 8; k <= 13; k++) wcode(k, 0);
    wcode(14, 0);
    run(8, 8, "R9 negative saturation");
    chk("R9 bottom", result, 32'h80000000);

    for (int k = 1; k <= 13; k++) begin wcode(k, 1); wwt(k, 8388608); end
    wcode(14, 2);
    begin
      int e;
      @(negedge clk); start = 1; start_sel = 4'd2;
      @(negedge clk); start = 0;
      @(negedge clk); chk("R10 no early done", done, 0);
      start = 1; start_sel = 4'd14;
      @(negedge clk); start = 0; e = 1;
      while (!done && e < 40) begin @(negedge clk); e++; end
      chk("R10 restart latency", e, 2);
      chk("R10 restart value", longint'($signed(result)), model(14));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule